// File: doc/BRIEF.md
# Guarded Control Register Transaction Controller

This block sits behind a two-wire serial bus front end and owns one control register. The front end hands it bus events one at a time: start, stop, a received byte, and a request for a byte to transmit. The block answers each received byte with an acknowledge or a refusal one cycle later, and answers each transmit request with a read-data byte. The register is reached only through a slave byte whose upper nibble is `1011`. Bit 0 of that slave byte selects reading (1) or writing (0), and bit 1 carries address bit 8.

A write is an address byte plus exactly one data byte. Nothing changes until the stop that ends the transaction. Writes are guarded by two volatile latches that must be armed in order: a write of `02h` arms the first, then a write of `06h` arms the second. Only then does a field write take effect. That write launches a timed nonvolatile store of five retained fields and disarms both latches. While the store runs the block refuses all bus traffic and raises a busy flag. The new field values appear on the outputs when the store ends.

Top module: `ctlreg_if`

## Requirements
- R1: A slave byte is acknowledged only when its bits 7:4 equal `1011`. Any other slave byte is refused, and every byte after it is refused until the next start.
- R2: After a write slave byte (bit 0 = 0), the address byte is acknowledged only when {slave bit 1, address byte} equals `1FFh`. Otherwise it is refused and the rest of the transaction is ignored.
- R3: The first data byte of a write is acknowledged. Every later data byte in the same transaction is refused. The stop then acts on the first data byte.
- R4: A committed data byte of `02h` sets the write latch (read bit 1). A committed `06h` sets the register latch (read bit 2), but only while the write latch is set; otherwise it has no effect.
- R5: With the register latch set, a committed data byte whose bits 2:1 are `01` starts a store and clears both latches. The stored values are pup = {d7, d0}, wdt = {d6, d5} and prot = d4.
- R6: A field write committed while the register latch is clear is acknowledged but leaves the fields, the latches and the busy flag unchanged.
- R7: Data takes effect only when a stop follows it. A transaction that ends with a repeated start discards its data byte.
- R8: `store_busy` is high for exactly STORE_CYCLES cycles, starting the cycle after the stop. The fields change only at the edge where busy falls, and are visible in the first cycle with busy low.
- R9: While `store_busy` is high, every received byte is refused and every read request returns `FFh`.
- R10: A read slave byte (bit 0 = 1) followed by one read request returns {pup[1], wdt[1], wdt[0], prot, 0, rwel, wel, pup[0]}. The transaction then ends without needing a stop, and later read requests return `FFh`.
- R11: Read bit 3 is always 0, even after a field write with data bit 3 set.
- R12: Reset clears both latches, `store_busy`, `ack_vld` and `rd_vld`, and sets the fields to NV_INIT (ordered pup, wdt, prot).
- R13: `ack_vld` and `ack` appear one cycle after `ev_byte`. `rd_vld` and `rd_data` appear one cycle after `ev_rd`. Latch changes are visible the cycle after the stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ev_start | input | 1 | Start or repeated start seen |
| ev_stop | input | 1 | Stop seen |
| ev_byte | input | 1 | Received byte valid on byte_in |
| byte_in | input | 8 | Received byte |
| ev_rd | input | 1 | Front end requests a byte to transmit |
| ack_vld | output | 1 | Acknowledge decision valid |
| ack | output | 1 | 1 = acknowledge, 0 = refuse |
| rd_vld | output | 1 | Read data valid |
| rd_data | output | 8 | Byte to transmit |
| pup_sel | output | 2 | Retained field pup |
| wdt_sel | output | 2 | Retained field wdt |
| blk_prot | output | 1 | Retained field prot |
| wr_en_lat | output | 1 | Write latch |
| reg_wr_lat | output | 1 | Register latch |
| store_busy | output | 1 | Nonvolatile store in progress |

## Verification
Two events can meet in one cycle: the end of the store, and a new slave byte or read request arriving on the bus. The bench launches a store, then places a read request mid-store and a slave byte exactly in the last busy cycle; both must be refused. A slave byte one transaction later must be acknowledged, and it must read back the new fields. A behavioural model running alongside decides, cycle by cycle, which side of the boundary each event falls on.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

   typedef enum logic [2:0] {
      PH_IDLE, PH_SLV, PH_ADDR, PH_DATA, PH_HELD, PH_RD, PH_SKIP
   } phase_e;

   typedef struct packed {
      logic [1:0] pup;
      logic [1:0] wdt;
      logic       prot;
   } nv_t;

   localparam logic [7:0] IDLE_BYTE = 8'hFF;
   localparam logic [7:0] CMD_ARM_WR  = 8'h02;
   localparam logic [7:0] CMD_ARM_REG = 8'h06;

   function automatic logic [7:0] reg_view(nv_t nv, logic rwel, logic wel);
      return {nv.pup[1], nv.wdt, nv.prot, 1'b0, rwel, wel, nv.pup[0]};
   endfunction

endpackage

// File: rtl/ctlreg_seq.sv
module ctlreg_seq
   import ctlreg_pkg::*;
#(
   parameter logic [3:0] SEL_NIBBLE = 4'hB,
   parameter logic [8:0] REG_ADDR   = 9'h1FF
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ev_start,
   input  logic       ev_stop,
   input  logic       ev_byte,
   input  logic [7:0] byte_in,
   input  logic       ev_rd,
   input  logic       busy,
   input  logic [7:0] view,
   output logic       ack_vld,
   output logic       ack,
   output logic       rd_vld,
   output logic [7:0] rd_data,
   output logic       commit,
   output logic [7:0] commit_data
);

   phase_e     ph_q, ph_n;
   logic       a8_q, a8_n;
   logic [7:0] data_q, data_n;
   logic       ack_n;
   logic [7:0] rd_n;

   always_comb begin
      ph_n   = ph_q;
      a8_n   = a8_q;
      data_n = data_q;
      ack_n  = 1'b0;
      rd_n   = IDLE_BYTE;
      commit = 1'b0;
      if (ev_start) begin
         ph_n = PH_SLV;
      end else if (ev_stop) begin
         commit = (ph_q == PH_HELD);
         ph_n   = PH_IDLE;
      end else if (ev_byte) begin
         if (busy) begin
            ph_n = PH_SKIP;
         end else begin
            unique case (ph_q)
               PH_SLV: begin
                  if (byte_in[7:4] == SEL_NIBBLE) begin
                     ack_n = 1'b1;
                     if (byte_in[0]) ph_n = PH_RD;
                     else begin
                        a8_n = byte_in[1];
                        ph_n = PH_ADDR;
                     end
                  end else begin
                     ph_n = PH_SKIP;
                  end
               end
               PH_ADDR: begin
                  if ({a8_q, byte_in} == REG_ADDR) begin
                     ack_n = 1'b1;
                     ph_n  = PH_DATA;
                  end else begin
                     ph_n = PH_SKIP;
                  end
               end
               PH_DATA: begin
                  ack_n  = 1'b1;
                  data_n = byte_in;
                  ph_n   = PH_HELD;
               end
               PH_HELD: ph_n = PH_HELD;
               default: ph_n = PH_SKIP;
            endcase
         end
      end else if (ev_rd) begin
         if (ph_q == PH_RD && !busy) begin
            rd_n = view;
            ph_n = PH_IDLE;
         end
      end
   end

   assign commit_data = data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q    <= PH_IDLE;
         a8_q    <= 1'b0;
         data_q  <= '0;
         ack_vld <= 1'b0;
         ack     <= 1'b0;
         rd_vld  <= 1'b0;
         rd_data <= IDLE_BYTE;
      end else begin
         ph_q    <= ph_n;
         a8_q    <= a8_n;
         data_q  <= data_n;
         ack_vld <= ev_byte;
         ack     <= ack_n;
         rd_vld  <= ev_rd;
         rd_data <= rd_n;
      end
   end

endmodule

// File: rtl/ctlreg_latch.sv
module ctlreg_latch
   import ctlreg_pkg::*;
#(
   parameter logic [4:0] NV_INIT = 5'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       commit,
   input  logic [7:0] cdata,
   input  logic       store_done,
   output nv_t        nv,
   output logic       wel,
   output logic       rwel,
   output logic       store_go
);

   nv_t pend_q;

   assign store_go = commit && rwel && (cdata[2:1] == 2'b01);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nv     <= nv_t'(NV_INIT);
         pend_q <= nv_t'(NV_INIT);
         wel    <= 1'b0;
         rwel   <= 1'b0;
      end else begin
         if (store_go) begin
            pend_q <= '{pup: {cdata[7], cdata[0]}, wdt: cdata[6:5], prot: cdata[4]};
            wel    <= 1'b0;
            rwel   <= 1'b0;
         end else if (commit && cdata == CMD_ARM_WR) begin
            wel <= 1'b1;
         end else if (commit && cdata == CMD_ARM_REG && wel) begin
            rwel <= 1'b1;
         end
         if (store_done) nv <= pend_q;
      end
   end

endmodule

// File: rtl/ctlreg_timer.sv
module ctlreg_timer #(
   parameter int CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   output logic busy,
   output logic done
);

   generate
      if (CYCLES == 1) begin : g_single
         logic busy_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) busy_q <= 1'b0;
            else        busy_q <= go;
         end
         assign busy = busy_q;
         assign done = busy_q;
      end else begin : g_count
         localparam int CNT_W = $clog2(CYCLES + 1);
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              cnt_q <= '0;
            else if (go)             cnt_q <= CNT_W'(CYCLES);
            else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
         end
         assign busy = (cnt_q != '0);
         assign done = (cnt_q == CNT_W'(1));
      end
   endgenerate

endmodule

// File: rtl/ctlreg_if.sv
module ctlreg_if
   import ctlreg_pkg::*;
#(
   parameter int         STORE_CYCLES = 64,
   parameter logic [3:0] SEL_NIBBLE   = 4'hB,
   parameter logic [8:0] REG_ADDR     = 9'h1FF,
   parameter logic [4:0] NV_INIT      = 5'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ev_start,
   input  logic       ev_stop,
   input  logic       ev_byte,
   input  logic [7:0] byte_in,
   input  logic       ev_rd,
   output logic       ack_vld,
   output logic       ack,
   output logic       rd_vld,
   output logic [7:0] rd_data,
   output logic [1:0] pup_sel,
   output logic [1:0] wdt_sel,
   output logic       blk_prot,
   output logic       wr_en_lat,
   output logic       reg_wr_lat,
   output logic       store_busy
);

   generate
      if (STORE_CYCLES < 1) begin : g_bad_cycles
         $error("STORE_CYCLES must be at least 1");
      end
      if (REG_ADDR[8] !== 1'b0 && REG_ADDR[8] !== 1'b1) begin : g_bad_addr
         $error("REG_ADDR must be fully specified");
      end
   endgenerate

   nv_t        nv;
   logic       commit, store_go, store_done;
   logic [7:0] commit_data;
   logic [7:0] view;

   assign view = reg_view(nv, reg_wr_lat, wr_en_lat);

   ctlreg_seq #(.SEL_NIBBLE(SEL_NIBBLE), .REG_ADDR(REG_ADDR)) seq_i (
      .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
      .ev_byte(ev_byte), .byte_in(byte_in), .ev_rd(ev_rd), .busy(store_busy),
      .view(view), .ack_vld(ack_vld), .ack(ack), .rd_vld(rd_vld),
      .rd_data(rd_data), .commit(commit), .commit_data(commit_data)
   );

   ctlreg_latch #(.NV_INIT(NV_INIT)) latch_i (
      .clk(clk), .rst_n(rst_n), .commit(commit), .cdata(commit_data),
      .store_done(store_done), .nv(nv), .wel(wr_en_lat), .rwel(reg_wr_lat),
      .store_go(store_go)
   );

   ctlreg_timer #(.CYCLES(STORE_CYCLES)) timer_i (
      .clk(clk), .rst_n(rst_n), .go(store_go), .busy(store_busy), .done(store_done)
   );

   assign pup_sel  = nv.pup;
   assign wdt_sel  = nv.wdt;
   assign blk_prot = nv.prot;

endmodule

// File: rtl/ctlreg_if_chk.sv
module ctlreg_if_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       ev_byte,
   input logic       ev_rd,
   input logic       ack_vld,
   input logic       ack,
   input logic       rd_vld,
   input logic [7:0] rd_data,
   input logic [1:0] pup_sel,
   input logic [1:0] wdt_sel,
   input logic       blk_prot,
   input logic       wr_en_lat,
   input logic       reg_wr_lat,
   input logic       store_busy
);

   a_r13_ack_follows_byte: assert property (@(posedge clk) disable iff (!rst_n)
      ev_byte |=> ack_vld);

   a_r13_no_spurious_ack: assert property (@(posedge clk) disable iff (!rst_n)
      !ev_byte |=> !ack_vld);

   a_r13_rd_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      ev_rd |=> rd_vld);

   a_r9_nack_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (store_busy && ev_byte) |=> (ack_vld && !ack));

   a_r9_ff_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (store_busy && ev_rd) |=> (rd_data == 8'hFF));

   a_r11_bit3_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_vld && rd_data != 8'hFF) |-> !rd_data[3]);

   a_r8_fields_move_only_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      !store_busy |=> $stable({pup_sel, wdt_sel, blk_prot}));

   a_r5_latches_clear_on_store: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(store_busy) |-> (!wr_en_lat && !reg_wr_lat));

endmodule

bind ctlreg_if ctlreg_if_chk chk_i (
   .clk(clk), .rst_n(rst_n), .ev_byte(ev_byte), .ev_rd(ev_rd),
   .ack_vld(ack_vld), .ack(ack), .rd_vld(rd_vld), .rd_data(rd_data),
   .pup_sel(pup_sel), .wdt_sel(wdt_sel), .blk_prot(blk_prot),
   .wr_en_lat(wr_en_lat), .reg_wr_lat(reg_wr_lat), .store_busy(store_busy)
);

// File: tb/ctlreg_if_tb_top.sv
module ctlreg_if_tb_top;

   localparam int CLK_NS = 10;
   localparam int STORE  = 6;
   localparam logic [4:0] INIT = 5'b10011; // pup=10 wdt=01 prot=1 -> reads B0h

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ev_start = 1'b0, ev_stop = 1'b0, ev_byte = 1'b0, ev_rd = 1'b0;
   logic [7:0] byte_in = 8'h00;
   logic       ack_vld, ack, rd_vld, store_busy, wr_en_lat, reg_wr_lat, blk_prot;
   logic [7:0] rd_data;
   logic [1:0] pup_sel, wdt_sel;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(CLK_NS/2) clk = ~clk;

   ctlreg_if #(.STORE_CYCLES(STORE), .NV_INIT(INIT)) dut_i (
      .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
      .ev_byte(ev_byte), .byte_in(byte_in), .ev_rd(ev_rd),
      .ack_vld(ack_vld), .ack(ack), .rd_vld(rd_vld), .rd_data(rd_data),
      .pup_sel(pup_sel), .wdt_sel(wdt_sel), .blk_prot(blk_prot),
      .wr_en_lat(wr_en_lat), .reg_wr_lat(reg_wr_lat), .store_busy(store_busy)
   );

   // ---------------- behavioural reference model ----------------
   // phase: 0 idle, 1 expect slave, 2 expect addr, 3 expect data, 4 data held, 5 read, 6 skip
   int         m_phase;
   bit         m_a8, m_wel, m_rwel, m_ackv, m_ack, m_rdv, m_busy;
   logic [7:0] m_data, m_rd;
   logic [4:0] m_nv, m_pend;  // {pup1, pup0, wdt1, wdt0, prot}
   int         m_left;

   function automatic logic [7:0] m_view();
      return {m_nv[4], m_nv[2], m_nv[1], m_nv[0], 1'b0, m_rwel, m_wel, m_nv[3]};
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_phase = 0; m_a8 = 0; m_wel = 0; m_rwel = 0; m_ackv = 0; m_ack = 0;
         m_rdv = 0; m_rd = 8'hFF; m_data = 0; m_nv = INIT; m_pend = INIT; m_left = 0;
      end else begin
         m_busy = (m_left > 0);
         m_ackv = ev_byte; m_rdv = ev_rd; m_ack = 0; m_rd = 8'hFF;
         if (m_left > 0) begin
            m_left = m_left - 1;
            if (m_left == 0) m_nv = m_pend;
         end
         if (ev_start) m_phase = 1;
         else if (ev_stop) begin
            if (m_phase == 4) begin
               if (m_rwel && m_data[2:1] == 2'b01) begin
                  m_pend = {m_data[7], m_data[0], m_data[6], m_data[5], m_data[4]};
                  m_wel = 0; m_rwel = 0; m_left = STORE;
               end else if (m_data == 8'h02) m_wel = 1;
               else if (m_data == 8'h06 && m_wel) m_rwel = 1;
            end
            m_phase = 0;
         end else if (ev_byte) begin
            if (m_busy) m_phase = 6;
            else if (m_phase == 1) begin
               if (byte_in[7:4] == 4'b1011) begin
                  m_ack = 1;
                  if (byte_in[0]) m_phase = 5;
                  else begin m_a8 = byte_in[1]; m_phase = 2; end
               end else m_phase = 6;
            end else if (m_phase == 2) begin
               if (m_a8 && byte_in == 8'hFF) begin m_ack = 1; m_phase = 3; end
               else m_phase = 6;
            end else if (m_phase == 3) begin
               m_ack = 1; m_data = byte_in; m_phase = 4;
            end else if (m_phase != 4) m_phase = 6;
         end else if (ev_rd) begin
            if (m_phase == 5 && !m_busy) begin m_rd = m_view(); m_phase = 0; end
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(ack_vld == m_ackv, "R13 model ack_vld", ack_vld, m_ackv);
         if (m_ackv) chk(ack == m_ack, "R1 model ack", ack, m_ack);
         chk(rd_vld == m_rdv, "R13 model rd_vld", rd_vld, m_rdv);
         if (m_rdv) chk(rd_data == m_rd, "R10 model rd_data", rd_data, m_rd);
         chk(store_busy == (m_left > 0), "R8 model busy", store_busy, (m_left > 0));
         chk({pup_sel, wdt_sel, blk_prot} == m_nv, "R5 model fields",
             {pup_sel, wdt_sel, blk_prot}, m_nv);
         chk({reg_wr_lat, wr_en_lat} == {m_rwel, m_wel}, "R4 model latches",
             {reg_wr_lat, wr_en_lat}, {m_rwel, m_wel});
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic do_start();
      ev_start = 1; tick(); ev_start = 0;
   endtask

   task automatic do_stop();
      ev_stop = 1; tick(); ev_stop = 0;
   endtask

   task automatic send(input logic [7:0] b, input bit exp_ack, input string tag);
      byte_in = b; ev_byte = 1; tick(); ev_byte = 0;
      chk(ack_vld && ack == exp_ack, tag, ack, exp_ack);
   endtask

   task automatic do_rd(input logic [7:0] exp, input string tag);
      ev_rd = 1; tick(); ev_rd = 0;
      chk(rd_vld && rd_data == exp, tag, rd_data, exp);
   endtask

   task automatic wr(input logic [7:0] d, input string tag);
      do_start(); send(8'hB2, 1, tag); send(8'hFF, 1, tag); send(d, 1, tag); do_stop();
   endtask

   task automatic rdreg(input logic [7:0] exp, input string tag);
      do_start(); send(8'hB1, 1, tag); do_rd(exp, tag);
   endtask

   initial begin
      #(CLK_NS * 200000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog all-requirements actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      rst_n = 1; tick();
      // R12 reset state
      chk(!store_busy && !wr_en_lat && !reg_wr_lat && !ack_vld && !rd_vld, "R12 reset flags",
          {store_busy, wr_en_lat, reg_wr_lat, ack_vld, rd_vld}, 0);
      chk({pup_sel, wdt_sel, blk_prot} == INIT, "R12 reset fields",
          {pup_sel, wdt_sel, blk_prot}, INIT);
      rdreg(8'hB0, "R10 initial read");
      do_stop();
      // R1 wrong preamble, rest refused
      do_start(); send(8'hA2, 0, "R1 bad preamble"); send(8'hFF, 0, "R1 skip rest"); do_stop();
      // R2 address bit 8 clear
      do_start(); send(8'hB0, 1, "R2 slave ok"); send(8'hFF, 0, "R2 addr 0FF refused"); do_stop();
      // R6 field write without register latch
      wr(8'hF3, "R6 write acked");
      chk(!store_busy, "R6 no store", store_busy, 0);
      rdreg(8'hB0, "R6 nothing changed");
      // R4 arm order
      wr(8'h06, "R4 06 first"); rdreg(8'hB0, "R4 06 without wel ignored");
      wr(8'h02, "R4 02"); rdreg(8'hB2, "R4 wel set");
      wr(8'h06, "R4 06"); rdreg(8'hB6, "R4 rwel set");
      // R7 repeated start discards data; also random read
      do_start(); send(8'hB2, 1, "R7"); send(8'hFF, 1, "R7"); send(8'h5B, 1, "R7 data");
      do_start(); send(8'hB1, 1, "R7 reread"); do_rd(8'hB6, "R7 data discarded");
      // R3/R5 field write with an extra byte
      do_start(); send(8'hB2, 1, "R5"); send(8'hFF, 1, "R5"); send(8'h5B, 1, "R3 first data");
      send(8'h00, 0, "R3 extra refused"); do_stop();
      chk(store_busy && !wr_en_lat && !reg_wr_lat, "R5 store started latches clear",
          {store_busy, wr_en_lat, reg_wr_lat}, 3'b100);
      chk({pup_sel, wdt_sel, blk_prot} == INIT, "R8 fields held during store",
          {pup_sel, wdt_sel, blk_prot}, INIT);
      begin
         int n = 0;
         while (store_busy && n < 100) begin n++; tick(); end
         chk(n == STORE, "R8 busy length", n, STORE);
      end
      chk({pup_sel, wdt_sel, blk_prot} == 5'b01101, "R5 fields stored",
          {pup_sel, wdt_sel, blk_prot}, 5'b01101);
      rdreg(8'h51, "R11 bit3 reads zero");
      do_rd(8'hFF, "R10 second read FF");
      // R9 / R8 boundary: last busy cycle versus first free cycle
      wr(8'h02, "R4 rearm"); wr(8'h06, "R4 rearm");
      wr(8'hA2, "R5 second store");
      do_start();
      do_rd(8'hFF, "R9 read during store");
      tick(); tick(); tick();
      send(8'hB1, 0, "R9 slave in last busy cycle");
      chk(!store_busy, "R8 busy ends", store_busy, 0);
      chk({pup_sel, wdt_sel, blk_prot} == 5'b10010, "R8 fields at busy fall",
          {pup_sel, wdt_sel, blk_prot}, 5'b10010);
      do_start(); send(8'hB1, 1, "R9 first free cycle acked");
      do_rd(8'hA0, "R10 new fields read");
      do_stop();
      repeat (2) tick();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule